// File: doc/BRIEF.md
# APB3 Slot Decoder and Response Multiplexer

This block sits between one APB3 master and up to sixteen APB slaves. The master drives a single select line. The block combines that line with four address bits to produce one select per slave slot. The four bits are taken from just above a parameterised slot-offset field. Address, write flag, enable and write data go out to every slave unchanged. Read data, ready and error from the addressed slot are steered back to the master.

All sixteen slots have the same size, 2^`SLOT_LOG2` locations, where `SLOT_LOG2` may be 8 to 20. Address bits above the slot index are not decoded, so the sixteen-slot window repeats throughout the address space. A per-slot bit mask marks slaves of the older kind that have no ready or error line. For those slots, ready is tied high and error is tied low at the multiplexer, so old and new slaves can share one fabric.

The block holds no state and has no clock. Decode and multiplexing are both pure combinational logic. A slave that stretches a transfer by holding ready low is therefore seen by the master in the same cycle. With the master select low, the fabric returns an idle response.

Top module: `apb_slot_fabric`

## Requirements
- R1: While `m_psel` is 1, exactly the select bit `s_psel[k]` is 1, where k is the unsigned value of `m_paddr[SLOT_LOG2+3:SLOT_LOG2]`.
- R2: While `m_psel` is 0, all bits of `s_psel` are 0.
- R3: Address bits above bit SLOT_LOG2+3 and below bit SLOT_LOG2 have no effect on which slot is selected. Addresses that differ only in those bits select the same slot.
- R4: `s_paddr`, `s_pwrite`, `s_penable` and `s_pwdata` equal `m_paddr`, `m_pwrite`, `m_penable` and `m_pwdata` at all times, whatever the select.
- R5: While `m_psel` is 1, `m_prdata` equals bits [k*DATA_W+DATA_W-1 : k*DATA_W] of `s_prdata`, where k is the selected slot.
- R6: While `m_psel` is 1 and slot k is not marked legacy, `m_pready` equals `s_pready[k]` in the same cycle. No register lies on this path.
- R7: While `m_psel` is 1 and slot k is not marked legacy, `m_pslverr` equals `s_pslverr[k]`.
- R8: If bit k of `LEGACY_MASK` is 1, selecting slot k gives `m_pready`=1 and `m_pslverr`=0 whatever `s_pready[k]` and `s_pslverr[k]` are. Read data is still taken from slot k.
- R9: While `m_psel` is 0, `m_prdata` is 0, `m_pready` is 1 and `m_pslverr` is 0, whatever the slave inputs are.
- R10: At no time is more than one bit of `s_psel` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_paddr | input | ADDR_W | Master address |
| m_psel | input | 1 | Master single select |
| m_penable | input | 1 | Master enable (access phase) |
| m_pwrite | input | 1 | Master write flag |
| m_pwdata | input | DATA_W | Master write data |
| m_prdata | output | DATA_W | Read data returned to master |
| m_pready | output | 1 | Ready returned to master |
| m_pslverr | output | 1 | Error returned to master |
| s_paddr | output | ADDR_W | Address forwarded to all slaves |
| s_penable | output | 1 | Enable forwarded to all slaves |
| s_pwrite | output | 1 | Write flag forwarded to all slaves |
| s_pwdata | output | DATA_W | Write data forwarded to all slaves |
| s_psel | output | 16 | One select per slot |
| s_prdata | input | 16*DATA_W | Read data of all slots, slot k at bits [k*DATA_W +: DATA_W] |
| s_pready | input | 16 | Ready of each slot |
| s_pslverr | input | 16 | Error of each slot |

## Verification
The bench builds the fabric with `SLOT_LOG2`=12 and 32-bit address and data. The slot index therefore sits at address bits 15:12. This leaves twelve offset bits below the index and sixteen alias bits above it to disturb, which exercises R3 from both sides. `LEGACY_MASK` is 16'h0030, so slots 4 and 5 are legacy slaves next to slot 6, an ordinary APB3 slave. Driving all three with ready low and error high shows the forced legacy response against a response passed through unchanged. Each slave returns a read-data word that encodes its slot number. A wrong steering choice shows up directly in the returned data.

// File: rtl/apb_fab_pkg.sv
package apb_fab_pkg;
    // Fixed slot count of the fabric and the width of its index.
    localparam int unsigned SLOTS    = 16;
    localparam int unsigned SLOT_IDX_W = $clog2(SLOTS);

    typedef logic [SLOT_IDX_W-1:0] slot_idx_t;
    typedef logic [SLOTS-1:0]      slot_vec_t;

    // One-hot vector for a slot index, gated by an enable.
    function automatic slot_vec_t slot_onehot(input slot_idx_t idx, input logic en);
        slot_vec_t v;
        v = '0;
        if (en) v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/apb_slot_decode.sv
module apb_slot_decode
    import apb_fab_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned SLOT_LOG2 = 12
) (
    input  logic [ADDR_W-1:0] paddr,
    input  logic              psel,
    output slot_idx_t         slot_idx,
    output slot_vec_t         slot_sel
);
    localparam int unsigned IDX_LSB = SLOT_LOG2;

    // The index field sits just above the slot offset. Everything else is ignored.
    assign slot_idx = paddr[IDX_LSB +: SLOT_IDX_W];

    // One slot enable per position, produced by a repeated comparator.
    for (genvar g = 0; g < SLOTS; g++) begin : g_sel
        assign slot_sel[g] = psel && (slot_idx == slot_idx_t'(g));
    end
endmodule

// File: rtl/apb_resp_mux.sv
module apb_resp_mux
    import apb_fab_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter logic [15:0] LEGACY_MASK = 16'h0000
) (
    input  logic                    psel,
    input  slot_idx_t               slot_idx,
    input  logic [SLOTS*DATA_W-1:0] rdata_in,
    input  slot_vec_t               ready_in,
    input  slot_vec_t               err_in,
    output logic [DATA_W-1:0]       rdata_out,
    output logic                    ready_out,
    output logic                    err_out
);
    slot_vec_t eff_ready;
    slot_vec_t eff_err;

    // Legacy slots have no ready or error lines, so tie them to a clean response.
    for (genvar g = 0; g < SLOTS; g++) begin : g_resp
        if (LEGACY_MASK[g]) begin : g_legacy
            assign eff_ready[g] = 1'b1;
            assign eff_err[g]   = 1'b0;
        end else begin : g_apb3
            assign eff_ready[g] = ready_in[g];
            assign eff_err[g]   = err_in[g];
        end
    end

    always_comb begin
        if (psel) begin
            rdata_out = rdata_in[slot_idx*DATA_W +: DATA_W];
            ready_out = eff_ready[slot_idx];
            err_out   = eff_err[slot_idx];
        end else begin
            rdata_out = '0;
            ready_out = 1'b1;
            err_out   = 1'b0;
        end
    end
endmodule

// File: rtl/apb_slot_fabric.sv
module apb_slot_fabric
    import apb_fab_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SLOT_LOG2   = 12,
    parameter logic [15:0] LEGACY_MASK = 16'h0000
) (
    input  logic [ADDR_W-1:0]       m_paddr,
    input  logic                    m_psel,
    input  logic                    m_penable,
    input  logic                    m_pwrite,
    input  logic [DATA_W-1:0]       m_pwdata,
    output logic [DATA_W-1:0]       m_prdata,
    output logic                    m_pready,
    output logic                    m_pslverr,
    output logic [ADDR_W-1:0]       s_paddr,
    output logic                    s_penable,
    output logic                    s_pwrite,
    output logic [DATA_W-1:0]       s_pwdata,
    output logic [15:0]             s_psel,
    input  logic [16*DATA_W-1:0]    s_prdata,
    input  logic [15:0]             s_pready,
    input  logic [15:0]             s_pslverr
);
    slot_idx_t idx;

    // Broadcast of the request fields.
    assign s_paddr   = m_paddr;
    assign s_penable = m_penable;
    assign s_pwrite  = m_pwrite;
    assign s_pwdata  = m_pwdata;

    apb_slot_decode #(
        .ADDR_W   (ADDR_W),
        .SLOT_LOG2(SLOT_LOG2)
    ) u_decode (
        .paddr   (m_paddr),
        .psel    (m_psel),
        .slot_idx(idx),
        .slot_sel(s_psel)
    );

    apb_resp_mux #(
        .DATA_W     (DATA_W),
        .LEGACY_MASK(LEGACY_MASK)
    ) u_mux (
        .psel     (m_psel),
        .slot_idx (idx),
        .rdata_in (s_prdata),
        .ready_in (s_pready),
        .err_in   (s_pslverr),
        .rdata_out(m_prdata),
        .ready_out(m_pready),
        .err_out  (m_pslverr)
    );
endmodule

// File: rtl/apb_slot_fabric_chk.sv
module apb_slot_fabric_chk #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SLOT_LOG2   = 12,
    parameter logic [15:0] LEGACY_MASK = 16'h0000
) (
    input logic [ADDR_W-1:0] m_paddr,
    input logic              m_psel,
    input logic [DATA_W-1:0] m_prdata,
    input logic              m_pready,
    input logic              m_pslverr,
    input logic [ADDR_W-1:0] s_paddr,
    input logic [15:0]       s_psel
);
    logic [3:0] field;
    assign field = m_paddr[SLOT_LOG2 +: 4];

    always_comb begin
        AST_IDLE_NO_SEL: assert (m_psel || s_psel == 16'h0000) else $error("idle select"); // R2
        AST_SEL_ONEHOT: assert ($onehot0(s_psel)) else $error("multi select"); // R10
        AST_SEL_MATCH: assert (!m_psel || s_psel == (16'h0001 << field)) else $error("wrong slot"); // R1
        AST_IDLE_RESP: assert (m_psel || (m_prdata == '0 && m_pready && !m_pslverr)) else $error("idle response"); // R9
        AST_ADDR_PASS: assert (s_paddr == m_paddr) else $error("address fanout"); // R4
        AST_LEGACY_RESP: assert (!m_psel || !LEGACY_MASK[field] || (m_pready && !m_pslverr)) else $error("legacy response"); // R8
    end
endmodule

bind apb_slot_fabric apb_slot_fabric_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SLOT_LOG2  (SLOT_LOG2),
    .LEGACY_MASK(LEGACY_MASK)
) u_chk (
    .m_paddr  (m_paddr),
    .m_psel   (m_psel),
    .m_prdata (m_prdata),
    .m_pready (m_pready),
    .m_pslverr(m_pslverr),
    .s_paddr  (s_paddr),
    .s_psel   (s_psel)
);

// File: tb/tb_apb_slot_fabric.sv
`timescale 1ns/1ps
module tb_apb_slot_fabric;
    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;
    localparam int unsigned LOG2 = 12;
    localparam logic [15:0] LEG = 16'h0030;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [AW-1:0]    m_paddr = '0;
    logic             m_psel = 1'b0;
    logic             m_penable = 1'b0;
    logic             m_pwrite = 1'b0;
    logic [DW-1:0]    m_pwdata = '0;
    logic [DW-1:0]    m_prdata;
    logic             m_pready;
    logic             m_pslverr;
    logic [AW-1:0]    s_paddr;
    logic             s_penable;
    logic             s_pwrite;
    logic [DW-1:0]    s_pwdata;
    logic [15:0]      s_psel;
    logic [16*DW-1:0] s_prdata;
    logic [15:0]      s_pready = '1;
    logic [15:0]      s_pslverr = '0;

    int n_chk = 0;
    int n_bad = 0;

    apb_slot_fabric #(.ADDR_W(AW), .DATA_W(DW), .SLOT_LOG2(LOG2), .LEGACY_MASK(LEG)) dut (
        .m_paddr(m_paddr), .m_psel(m_psel), .m_penable(m_penable), .m_pwrite(m_pwrite),
        .m_pwdata(m_pwdata), .m_prdata(m_prdata), .m_pready(m_pready), .m_pslverr(m_pslverr),
        .s_paddr(s_paddr), .s_penable(s_penable), .s_pwrite(s_pwrite), .s_pwdata(s_pwdata),
        .s_psel(s_psel), .s_prdata(s_prdata), .s_pready(s_pready), .s_pslverr(s_pslverr)
    );

    // Each slave answers with a word carrying its own slot number.
    for (genvar g = 0; g < 16; g++) begin : g_slv
        assign s_prdata[g*DW +: DW] = 32'hC0DE_0000 + g;
    end

    typedef struct packed {
        logic [31:0] addr;
        logic        sel;
        logic [15:0] rdy;
        logic [15:0] err;
        logic [15:0] x_sel;
        logic [31:0] x_data;
        logic        x_rdy;
        logic        x_err;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_0000, 1'b1, 16'hFFFF, 16'h0000, 16'h0001, 32'hC0DE_0000, 1'b1, 1'b0}, // R1 R5
        '{32'h0000_3004, 1'b1, 16'hFFF7, 16'h0000, 16'h0008, 32'hC0DE_0003, 1'b0, 1'b0}, // R6
        '{32'h0000_7FFC, 1'b1, 16'hFFFF, 16'h0080, 16'h0080, 32'hC0DE_0007, 1'b1, 1'b1}, // R7
        '{32'h0000_F000, 1'b1, 16'h7FFF, 16'h8000, 16'h8000, 32'hC0DE_000F, 1'b0, 1'b1}, // R6 R7
        '{32'hFFFF_2000, 1'b1, 16'hFFFF, 16'h0000, 16'h0004, 32'hC0DE_0002, 1'b1, 1'b0}, // R3
        '{32'h0000_4000, 1'b1, 16'h0000, 16'hFFFF, 16'h0010, 32'hC0DE_0004, 1'b1, 1'b0}, // R8
        '{32'h1234_5ABC, 1'b1, 16'h0000, 16'hFFFF, 16'h0020, 32'hC0DE_0005, 1'b1, 1'b0}, // R8 R3
        '{32'h0000_6000, 1'b1, 16'h0000, 16'hFFFF, 16'h0040, 32'hC0DE_0006, 1'b0, 1'b1}, // R6 R7
        '{32'h0000_3004, 1'b0, 16'h0000, 16'hFFFF, 16'h0000, 32'h0000_0000, 1'b1, 1'b0}, // R2 R9
        '{32'h0001_A000, 1'b1, 16'hFFFF, 16'h0000, 16'h0400, 32'hC0DE_000A, 1'b1, 1'b0}, // R3
        '{32'h0000_0FFF, 1'b1, 16'hFFFF, 16'h0000, 16'h0001, 32'hC0DE_0000, 1'b1, 1'b0}, // R3
        '{32'h0000_1000, 1'b1, 16'hFFFF, 16'h0000, 16'h0002, 32'hC0DE_0001, 1'b1, 1'b0}  // R1
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act == exp, req, act, exp);
    endtask

    logic wd_expired = 1'b0;
    initial begin
        repeat (5000) @(posedge clk);
        wd_expired = 1'b1;
    end

    initial begin : main
        // Start-up state: master idle.
        @(negedge clk);
        chk_eq("R2 start select", {16'h0, s_psel}, 32'h0);
        chk_eq("R9 start rdata", m_prdata, 32'h0);
        chk_eq("R9 start ready/err", {30'h0, m_pready, m_pslverr}, 32'h2);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            m_paddr   = VEC[i].addr;
            m_psel    = VEC[i].sel;
            s_pready  = VEC[i].rdy;
            s_pslverr = VEC[i].err;
            @(negedge clk);
            chk_eq($sformatf("R1 R2 R3 vec%0d select", i), {16'h0, s_psel}, {16'h0, VEC[i].x_sel});
            chk_eq($sformatf("R5 R9 vec%0d rdata", i), m_prdata, VEC[i].x_data);
            chk_eq($sformatf("R6 R8 vec%0d ready", i), {31'h0, m_pready}, {31'h0, VEC[i].x_rdy});
            chk_eq($sformatf("R7 R8 vec%0d error", i), {31'h0, m_pslverr}, {31'h0, VEC[i].x_err});
        end

        // Walk every slot, with alias bits set, and check one-hot decode.
        s_pready = '1; s_pslverr = '0; m_psel = 1'b1;
        for (int k = 0; k < 16; k++) begin
            m_paddr = 32'hA5A5_0000 | (k << LOG2) | 32'h0000_0123;
            @(negedge clk);
            chk_eq($sformatf("R1 R10 walk slot %0d", k), {16'h0, s_psel}, 32'h1 << k);
            chk_eq($sformatf("R5 walk slot %0d data", k), m_prdata, 32'hC0DE_0000 + k);
        end

        // Broadcast of the request fields, with and without a select.
        for (int j = 0; j < 4; j++) begin
            m_psel    = j[0];
            m_penable = j[1];
            m_pwrite  = ~j[0];
            m_pwdata  = 32'h1357_9BDF ^ (j * 32'h0101_0101);
            m_paddr   = 32'hDEAD_0000 + j * 32'h1004;
            @(negedge clk);
            chk_eq("R4 addr fanout", s_paddr, m_paddr);
            chk_eq("R4 wdata fanout", s_pwdata, m_pwdata);
            chk_eq("R4 ctl fanout", {30'h0, s_penable, s_pwrite}, {30'h0, m_penable, m_pwrite});
        end

        // Same-cycle wait state: ready toggles with no clock edge in between.
        m_psel = 1'b1; m_paddr = 32'h0000_9000; s_pready = '1;
        #1;
        chk_eq("R6 ready high", {31'h0, m_pready}, 32'h1);
        s_pready[9] = 1'b0;
        #1;
        chk_eq("R6 ready drop same cycle", {31'h0, m_pready}, 32'h0);
        s_pready[9] = 1'b1; s_pready[8] = 1'b0;
        #1;
        chk_eq("R6 other slot ignored", {31'h0, m_pready}, 32'h1);

        // Idle response with noisy slave inputs.
        m_psel = 1'b0; s_pready = '0; s_pslverr = '1;
        @(negedge clk);
        chk_eq("R9 idle rdata", m_prdata, 32'h0);
        chk_eq("R9 idle ready/err", {30'h0, m_pready, m_pslverr}, 32'h2);
        chk_eq("R2 idle select", {16'h0, s_psel}, 32'h0);

        if (wd_expired) check(1'b0, "watchdog", 32'h0, 32'h1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(posedge wd_expired) begin
        check(1'b0, "watchdog", 32'h0, 32'h1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule